// File: doc/BRIEF.md
# Serial Memory Slave Control Byte Decoder

This block is the address front end of a two-wire serial memory slave. It watches the already synchronised clock and data lines of the bus and detects Start and Stop conditions. It shifts in the first byte after every Start or repeated Start and checks that byte. The top nibble must carry the memory device-type code, and the next two bits must equal two board-level strap pins.

When the byte matches, the block pulls the data line low for the ninth clock as an acknowledge. In the same cycle it sends a one-cycle strobe to downstream logic. The strobe carries the requested direction and the block-select bit, which becomes bit 8 of the memory address. The block-select bit is never compared, so one device answers for both halves of its 512-byte array. Up to four devices can share a bus, each with its own strap setting. When the byte does not match, the block leaves the line released and ignores traffic until the next Start.

Top module: `mem_slave_addr_front`

## Requirements
- R1: After reset, `sda_pull_o` and `sel_stb_o` are 0.
- R2: A control byte whose bits [7:4] are 4'b1010 and whose bits [3] and [2] equal `strap_hi_i` and `strap_lo_i` is acknowledged. `sda_pull_o` rises after the falling edge of the eighth SCL pulse and falls after the falling edge of the ninth.
- R3: A byte whose bits [7:4] differ from 4'b1010 is not acknowledged and produces no strobe.
- R4: A byte whose bit [3] differs from `strap_hi_i`, or whose bit [2] differs from `strap_lo_i`, is not acknowledged and produces no strobe.
- R5: Bit [1] of the control byte is never compared. On a match it appears on `sel_blk_o` as memory address bit 8.
- R6: Bit [0] of the control byte selects the operation. On a match, `sel_read_o` is 1 for read and 0 for write.
- R7: Each acknowledged byte gives exactly one `sel_stb_o` pulse, one clock long, in the cycle in which `sda_pull_o` rises.
- R8: A Start (SDA falling while SCL is high) or a Stop (SDA rising while SCL is high) aborts a byte in progress and clears the bit count. After a Stop, nothing is acknowledged until a new Start.
- R9: After a mismatch, bytes sent without a new Start are ignored.
- R10: Only the first byte after a Start is decoded. Later bytes in the same transfer are not acknowledged and give no strobe.
- R11: SDA is sampled on each SCL rising edge, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line |
| strap_hi_i | input | 1 | Upper device-select strap pin |
| strap_lo_i | input | 1 | Lower device-select strap pin |
| sda_pull_o | output | 1 | Open-drain pull-down enable for the data line |
| sel_stb_o | output | 1 | One-cycle strobe on an accepted control byte |
| sel_read_o | output | 1 | Direction requested: 1 read, 0 write (valid with strobe) |
| sel_blk_o | output | 1 | Memory address bit 8 from the block-select bit (valid with strobe) |

## Verification
The assertions assume that SCL and SDA arrive already synchronised to `clk`, and that each bus level lasts at least two clocks, so every line edge is seen as a single event. They also assume that SDA changes while SCL is high only to form a Start or a Stop, and that the straps hold steady during a byte. The bench drives every bus phase for four clocks and changes SDA only while SCL is low, except inside its Start and Stop tasks. It sets the straps only while the bus is idle.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int          BYTE_W   = 8;
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_ACK  = 2'd2,
        ST_HOLD = 2'd3
    } dec_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic dbit;
    } bus_ev_t;

    typedef struct packed {
        logic [3:0] code;
        logic       cs_hi;
        logic       cs_lo;
        logic       blk;
        logic       rd;
    } ctl_fields_t;

    function automatic logic ctl_hit(input ctl_fields_t f,
                                     input logic hi, input logic lo);
        return (f.code == DEV_CODE) && (f.cs_hi == hi) && (f.cs_lo == lo);
    endfunction

endpackage

// File: rtl/i2cs_line_events.sv
module i2cs_line_events
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
        ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev_o.rise  = scl_i & ~scl_q;
        ev_o.fall  = ~scl_i & scl_q;
        ev_o.dbit  = sda_i;
    end

    assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_o.start, ev_o.stop, ev_o.rise, ev_o.fall}));

endmodule

// File: rtl/i2cs_ctl_match.sv
module i2cs_ctl_match
    import i2cs_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              strap_hi_i,
    input  logic              strap_lo_i,
    output logic              hit_o,
    output logic              rd_o,
    output logic              blk_o
);
    ctl_fields_t fields;

    always_comb begin
        fields = ctl_fields_t'(byte_i);
        hit_o  = ctl_hit(fields, strap_hi_i, strap_lo_i);
        rd_o   = fields.rd;
        blk_o  = fields.blk;
    end

endmodule

// File: rtl/i2cs_ctl_fsm.sv
module i2cs_ctl_fsm
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev_i,
    input  logic              hit_i,
    input  logic              rd_i,
    input  logic              blk_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              pull_o,
    output logic              stb_o,
    output logic              rd_o,
    output logic              blk_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    dec_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            pull_o <= 1'b0;
            stb_o  <= 1'b0;
            rd_o   <= 1'b0;
            blk_o  <= 1'b0;
        end else begin
            stb_o <= 1'b0;
            if (ev_i.start) begin
                state  <= ST_RECV;
                cnt    <= '0;
                shreg  <= '0;
                pull_o <= 1'b0;
            end else if (ev_i.stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                pull_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_RECV: begin
                        if (ev_i.rise && cnt < FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], ev_i.dbit};
                            cnt   <= cnt + 1'b1;
                        end else if (ev_i.fall && cnt == FULL) begin
                            if (hit_i) begin
                                pull_o <= 1'b1;
                                stb_o  <= 1'b1;
                                rd_o   <= rd_i;
                                blk_o  <= blk_i;
                                state  <= ST_ACK;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev_i.fall) begin
                            pull_o <= 1'b0;
                            state  <= ST_HOLD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign byte_o = shreg;

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);
    assert_strobe_with_pull_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_o) |-> stb_o);
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o);
    assert_ack_release_R2: assert property (@(posedge clk) disable iff (rst)
        (pull_o && ev_i.fall) |=> !pull_o);
    assert_stop_aborts_R8: assert property (@(posedge clk) disable iff (rst)
        ev_i.stop |=> (!pull_o && state == ST_IDLE));
    assert_start_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (state == ST_RECV && cnt == '0));
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !pull_o);
    assert_hold_silent_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> (!pull_o && !stb_o));

endmodule

// File: rtl/mem_slave_addr_front.sv
module mem_slave_addr_front
    import i2cs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic strap_hi_i,
    input  logic strap_lo_i,
    output logic sda_pull_o,
    output logic sel_stb_o,
    output logic sel_read_o,
    output logic sel_blk_o
);
    bus_ev_t           ev;
    logic [BYTE_W-1:0] rx_byte;
    logic              hit;
    logic              hit_rd;
    logic              hit_blk;

    i2cs_line_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cs_ctl_match u_match (
        .byte_i     (rx_byte),
        .strap_hi_i (strap_hi_i),
        .strap_lo_i (strap_lo_i),
        .hit_o      (hit),
        .rd_o       (hit_rd),
        .blk_o      (hit_blk)
    );

    i2cs_ctl_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (ev),
        .hit_i  (hit),
        .rd_i   (hit_rd),
        .blk_i  (hit_blk),
        .byte_o (rx_byte),
        .pull_o (sda_pull_o),
        .stb_o  (sel_stb_o),
        .rd_o   (sel_read_o),
        .blk_o  (sel_blk_o)
    );

endmodule

// File: tb/mem_slave_addr_front_bench.sv
`timescale 1ns/1ps
module mem_slave_addr_front_bench;

    localparam int H = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic shi = 1'b0;
    logic slo = 1'b0;
    logic sda_pull_o, sel_stb_o, sel_read_o, sel_blk_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    int   stb_seen = 0;
    logic stb_rd, stb_pg, stb_pull;

    always #2 clk = ~clk;

    mem_slave_addr_front u_mem_slave_addr_front (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda),
        .strap_hi_i (shi),
        .strap_lo_i (slo),
        .sda_pull_o (sda_pull_o),
        .sel_stb_o  (sel_stb_o),
        .sel_read_o (sel_read_o),
        .sel_blk_o  (sel_blk_o)
    );

    always @(negedge clk) begin
        if (sel_stb_o) begin
            stb_seen = stb_seen + 1;
            stb_rd   = sel_read_o;
            stb_pg   = sel_blk_o;
            stb_pull = sda_pull_o;
        end
    end

    // fields: [12:5] byte, [4] strap_hi, [3] strap_lo, [2] ack, [1] read, [0] blk
    localparam int NV = 10;
    localparam logic [12:0] VEC [NV] = '{
        {8'hA0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'hA1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'hA3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {8'hAE, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'hAC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hA8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'hB0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hAA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; hold();
        scl = 1'b1; hold();
        sda = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda = 1'b0; hold();
        scl = 1'b1; hold();
        sda = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        sda = b;    hold();
        scl = 1'b1; hold();
        scl = 1'b0; hold();
    endtask

    // early: pull seen during 8th high; acked: pull during 9th high; late: pull after 9th fall
    task automatic xfer(input logic [7:0] b, output logic early, output logic acked,
                        output logic late);
        early = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; hold();
            scl = 1'b1; hold();
            if (i == 0) early = sda_pull_o;
            scl = 1'b0; hold();
        end
        sda = 1'b1;
        scl = 1'b1; hold();
        acked = sda_pull_o;
        scl = 1'b0; hold();
        late = sda_pull_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic e, a, l;
        int   base;
        repeat (3) @(negedge clk);
        chk(sda_pull_o == 1'b0, "R1 pull", sda_pull_o, 0);
        chk(sel_stb_o == 1'b0, "R1 strobe", sel_stb_o, 0);
        rst = 1'b0;
        hold();

        for (int v = 0; v < NV; v++) begin
            shi = VEC[v][4];
            slo = VEC[v][3];
            hold();
            base = stb_seen;
            bus_start();
            xfer(VEC[v][12:5], e, a, l);
            bus_stop();
            // R2 R3 R4 R11: acknowledge window
            chk(e == 1'b0, "R2 early pull", e, 0);
            chk(a == VEC[v][2], "R2/R3/R4 ack", a, VEC[v][2]);
            chk(l == 1'b0, "R2 release", l, 0);
            // R7: exactly one strobe cycle per accepted byte
            chk(stb_seen - base == int'(VEC[v][2]), "R7 strobe count",
                stb_seen - base, VEC[v][2]);
            if (VEC[v][2]) begin
                chk(stb_pull == 1'b1, "R7 strobe with pull", stb_pull, 1);
                chk(stb_rd == VEC[v][1], "R6 direction", stb_rd, VEC[v][1]);
                chk(stb_pg == VEC[v][0], "R5 block bit", stb_pg, VEC[v][0]);
            end
        end

        shi = 1'b0; slo = 1'b0; hold();

        // R8: Stop mid-byte aborts, nothing acknowledged afterwards
        base = stb_seen;
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(i[0]);
        bus_stop();
        xfer(8'hA0, e, a, l);
        chk(a == 1'b0, "R8 after stop", a, 0);
        chk(stb_seen == base, "R8 strobe after stop", stb_seen - base, 0);

        // R8: repeated Start mid-byte restarts the bit count
        base = stb_seen;
        bus_start();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_start();
        xfer(8'hA1, e, a, l);
        chk(a == 1'b1, "R8 repeated start ack", a, 1);
        chk(stb_seen - base == 1, "R8 strobe after restart", stb_seen - base, 1);
        chk(stb_rd == 1'b1, "R6 read after restart", stb_rd, 1);
        bus_stop();

        // R9: after mismatch, following bytes ignored without a Start
        base = stb_seen;
        bus_start();
        xfer(8'h00, e, a, l);
        chk(a == 1'b0, "R9 mismatch", a, 0);
        xfer(8'hA0, e, a, l);
        chk(a == 1'b0, "R9 ignored byte", a, 0);
        chk(stb_seen == base, "R9 no strobe", stb_seen - base, 0);
        bus_stop();

        // R10: second byte of a transfer is not decoded
        base = stb_seen;
        bus_start();
        xfer(8'hA0, e, a, l);
        chk(a == 1'b1, "R10 first byte ack", a, 1);
        xfer(8'hA0, e, a, l);
        chk(a == 1'b0, "R10 second byte", a, 0);
        chk(stb_seen - base == 1, "R10 strobe count", stb_seen - base, 1);
        // R10: a repeated Start after an accepted byte decodes again
        bus_start();
        xfer(8'hA3, e, a, l);
        chk(a == 1'b1, "R10 repeated start ack", a, 1);
        chk(stb_pg == 1'b1, "R5 block after repeated start", stb_pg, 1);
        bus_stop();

        // R11: byte-reversed pattern of a valid code is rejected (MSB first)
        bus_start();
        xfer(8'h05, e, a, l);
        chk(a == 1'b0, "R11 bit order", a, 0);
        bus_stop();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule